// File: doc/BRIEF.md
# Per-Line Fast Command Delay

This block sits behind the fast-control link of a front-end module. Once per bunch-crossing clock it takes in a 24-bit command word together with the crossing identifier that the word refers to. Commands are sent out early, well before the crossing they concern. The link carries all lines with the same latency and cannot shift individual lines. Each command line therefore needs its own local delay, so that detector, cable and processing latencies are matched line by line.

Every clock, the block records the command word and its crossing identifier in a 32-entry circular history. Each command bit then picks its own entry from that history, using a 5-bit delay setting. Each output bit travels with the crossing identifier taken from the same history entry. Downstream logic can therefore tag its data with the crossing the command was issued for. A delay setting of zero gives a single register stage. A reset clears the whole history.

Top module: `tcd_top`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, every output bit and every output crossing field reads zero. A reset clears the history, so a bit whose delay reaches back past the reset reads zero with crossing zero.
- R2: With a delay setting of 0, output bit b equals input command bit b from the previous clock.
- R3: With a delay setting d from 1 to 31, output bit b at cycle t+1+d equals input command bit b of cycle t.
- R4: Each command line follows only its own setting: lines with different settings in the same run each meet R2/R3 independently.
- R5: Output crossing field b (bits 12b+11..12b of the crossing output) equals the crossing identifier that arrived in the same cycle as the command bit now shown on line b.
- R6: A new delay setting applied before a clock edge governs the output registered at that edge. No further cycles of the old setting appear.
- R7: The largest setting, 31, returns the input from 32 clock edges earlier (31 cycles plus the output register), with no aliasing inside the 32-entry history.
- R8: The delay setting for line b is the 5-bit field at bits 5b+4..5b of the configuration input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_i | input | 24 | Command word for this cycle |
| bxid_i | input | 12 | Crossing identifier of this command word |
| dly_cfg_i | input | 120 | Per-line delay settings, 5 bits per line |
| cmd_o | output | 24 | Delayed command lines |
| bxid_o | output | 288 | Crossing identifier per line, 12 bits per line |

## Verification
The bench builds the block with its default parameters: 24 lines, a 5-bit delay and a 12-bit crossing identifier. With those defaults the whole delay range of 0 to 31 fits in a run of a few hundred cycles. The bench uses a spread of per-line settings in which every value from 0 to 23 occurs together on adjacent lines. It also runs all lines at 31 to probe wrap-around in the history, changes settings in the middle of a stream, and resets with data in flight. A behavioural queue model predicts every line and crossing field on every clock.

// File: rtl/tcd_pkg.sv
// Shared constants for the per-line command delay.
// Assumes one command word per clock; the defaults match a 24-line link.
package tcd_pkg;
    localparam int unsigned TCD_CMD_W = 24;  // command lines
    localparam int unsigned TCD_DLY_W = 5;   // delay setting width
    localparam int unsigned TCD_ID_W  = 12;  // crossing identifier width
endpackage

// File: rtl/tcd_history.sv
// Circular history of command words and crossing identifiers.
// Writes one entry per clock at the write pointer. It offers one read port per
// command line, and each port returns that line's bit plus the identifier
// stored in the same entry. Assumes that read addresses come from the taps.
module tcd_history #(
    parameter int unsigned CMD_W = 24,
    parameter int unsigned ID_W  = 12,
    parameter int unsigned AW    = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CMD_W-1:0]      wr_cmd,
    input  logic [ID_W-1:0]       wr_id,
    output logic [AW-1:0]         wptr_o,
    input  logic [CMD_W*AW-1:0]   rd_addr,
    output logic [CMD_W-1:0]      rd_bit,
    output logic [CMD_W*ID_W-1:0] rd_id
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [CMD_W-1:0] mem_cmd [DEPTH];
    logic [ID_W-1:0]  mem_id  [DEPTH];
    logic [AW-1:0]    wptr;

    // Record the incoming word each cycle; a reset clears every entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem_cmd[i] <= '0;
                mem_id[i]  <= '0;
            end
        end else begin
            mem_cmd[wptr] <= wr_cmd;
            mem_id[wptr]  <= wr_id;
            wptr          <= wptr + AW'(1);
        end
    end

    assign wptr_o = wptr;

    // One read port per line, indexed by that line's address.
    for (genvar b = 0; b < CMD_W; b++) begin : g_rd
        logic [AW-1:0] a;
        assign a                     = rd_addr[b*AW +: AW];
        assign rd_bit[b]             = mem_cmd[a][b];
        assign rd_id[b*ID_W +: ID_W] = mem_id[a];
    end
endmodule

// File: rtl/tcd_tap.sv
// Delay tap for one command line.
// Turns the delay setting into a history address relative to the write
// pointer. A setting of zero bypasses the history. The result is then
// registered. Assumes that the history holds at least 2**AW entries.
module tcd_tap #(
    parameter int unsigned ID_W = 12,
    parameter int unsigned AW   = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   dly,
    input  logic [AW-1:0]   wptr,
    input  logic            cmd_now,
    input  logic [ID_W-1:0] id_now,
    input  logic            hist_bit,
    input  logic [ID_W-1:0] hist_id,
    output logic [AW-1:0]   rd_addr,
    output logic            cmd_o,
    output logic [ID_W-1:0] id_o
);
    // Entry written dly cycles ago.
    assign rd_addr = wptr - dly;

    // Register the chosen bit and identifier (bypass for zero delay).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_o <= 1'b0;
            id_o  <= '0;
        end else if (dly == '0) begin
            cmd_o <= cmd_now;
            id_o  <= id_now;
        end else begin
            cmd_o <= hist_bit;
            id_o  <= hist_id;
        end
    end
endmodule

// File: rtl/tcd_top.sv
// Per-line fast command delay.
// Each of the CMD_W lines is delayed by its own setting of 0 to 2**DLY_W-1
// cycles, plus one register stage, and carries the crossing identifier of
// the word it came from. Assumes that commands arrive early enough that only
// added latency is needed.
module tcd_top #(
    parameter int unsigned CMD_W = tcd_pkg::TCD_CMD_W,
    parameter int unsigned DLY_W = tcd_pkg::TCD_DLY_W,
    parameter int unsigned ID_W  = tcd_pkg::TCD_ID_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CMD_W-1:0]      cmd_i,
    input  logic [ID_W-1:0]       bxid_i,
    input  logic [CMD_W*DLY_W-1:0] dly_cfg_i,
    output logic [CMD_W-1:0]      cmd_o,
    output logic [CMD_W*ID_W-1:0] bxid_o
);
    logic [DLY_W-1:0]        wptr;
    logic [CMD_W*DLY_W-1:0]  rd_addr;
    logic [CMD_W-1:0]        rd_bit;
    logic [CMD_W*ID_W-1:0]   rd_id;

    tcd_history #(.CMD_W(CMD_W), .ID_W(ID_W), .AW(DLY_W)) u_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_cmd  (cmd_i),
        .wr_id   (bxid_i),
        .wptr_o  (wptr),
        .rd_addr (rd_addr),
        .rd_bit  (rd_bit),
        .rd_id   (rd_id)
    );

    // One tap per command line.
    for (genvar b = 0; b < CMD_W; b++) begin : g_tap
        tcd_tap #(.ID_W(ID_W), .AW(DLY_W)) u_tap (
            .clk      (clk),
            .rst_n    (rst_n),
            .dly      (dly_cfg_i[b*DLY_W +: DLY_W]),
            .wptr     (wptr),
            .cmd_now  (cmd_i[b]),
            .id_now   (bxid_i),
            .hist_bit (rd_bit[b]),
            .hist_id  (rd_id[b*ID_W +: ID_W]),
            .rd_addr  (rd_addr[b*DLY_W +: DLY_W]),
            .cmd_o    (cmd_o[b]),
            .id_o     (bxid_o[b*ID_W +: ID_W])
        );
    end
endmodule

// File: rtl/tcd_checker.sv
// Timing properties of tcd_top, checked at its ports. Bound to every instance.
module tcd_checker #(
    parameter int unsigned CMD_W = 24,
    parameter int unsigned DLY_W = 5,
    parameter int unsigned ID_W  = 12
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [CMD_W-1:0]       cmd_i,
    input logic [ID_W-1:0]        bxid_i,
    input logic [CMD_W*DLY_W-1:0] dly_cfg_i,
    input logic [CMD_W-1:0]       cmd_o,
    input logic [CMD_W*ID_W-1:0]  bxid_o
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (cmd_o == '0 && bxid_o == '0));

    for (genvar b = 0; b < CMD_W; b++) begin : g_line
        // R2
        zero_dly_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(dly_cfg_i[b*DLY_W +: DLY_W]) == '0)
            |-> cmd_o[b] == $past(cmd_i[b]));
        // R5
        zero_dly_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(dly_cfg_i[b*DLY_W +: DLY_W]) == '0)
            |-> bxid_o[b*ID_W +: ID_W] == $past(bxid_i));
        // R3
        one_dly_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(rst_n, 2) &&
             $past(dly_cfg_i[b*DLY_W +: DLY_W]) == DLY_W'(1))
            |-> cmd_o[b] == $past(cmd_i[b], 2));
    end
endmodule

bind tcd_top tcd_checker #(.CMD_W(CMD_W), .DLY_W(DLY_W), .ID_W(ID_W)) u_tcd_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_i     (cmd_i),
    .bxid_i    (bxid_i),
    .dly_cfg_i (dly_cfg_i),
    .cmd_o     (cmd_o),
    .bxid_o    (bxid_o)
);

// File: tb/tb_tcd_top.sv
module tb_tcd_top;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 24;
    localparam int DW = 5;
    localparam int IW = 12;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [CW-1:0]   cmd_i;
    logic [IW-1:0]   bxid_i;
    logic [CW*DW-1:0] dly_cfg_i;
    logic [CW-1:0]   cmd_o;
    logic [CW*IW-1:0] bxid_o;

    int n_chk = 0;
    int n_bad = 0;

    // Reference model state: every word accepted since the last reset.
    logic [CW-1:0] q_cmd[$];
    logic [IW-1:0] q_id[$];
    logic [CW-1:0]    exp_cmd;
    logic [CW*IW-1:0] exp_id;

    tcd_top dut (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .bxid_i(bxid_i),
        .dly_cfg_i(dly_cfg_i), .cmd_o(cmd_o), .bxid_o(bxid_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic summary_and_end();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        summary_and_end();
    end

    // Compare the outputs with the model (called away from the clock edge).
    task automatic compare(input string tag);
        n_chk++;
        if (cmd_o !== exp_cmd) begin
            n_bad++;
            $display("FAIL %s cmd: got %h expected %h", tag, cmd_o, exp_cmd);
        end
        n_chk++;
        if (bxid_o !== exp_id) begin
            n_bad++;
            $display("FAIL %s/R5 crossing: got %h expected %h", tag, bxid_o, exp_id);
        end
    endtask

    // Compare the outputs, apply a new input, predict the next output, advance one clock.
    task automatic step(input logic [CW-1:0] c, input logic [IW-1:0] id,
                        input logic [CW*DW-1:0] cfg, input string tag);
        compare(tag);
        cmd_i = c; bxid_i = id; dly_cfg_i = cfg;
        for (int b = 0; b < CW; b++) begin
            int d = int'(cfg[b*DW +: DW]);
            int n = q_cmd.size();
            if (d == 0) begin
                exp_cmd[b] = c[b]; exp_id[b*IW +: IW] = id;
            end else if (d <= n) begin
                exp_cmd[b] = q_cmd[n-d][b]; exp_id[b*IW +: IW] = q_id[n-d];
            end else begin
                exp_cmd[b] = 1'b0; exp_id[b*IW +: IW] = '0;
            end
        end
        q_cmd.push_back(c); q_id.push_back(id);
        @(posedge clk); @(negedge clk);
    endtask

    // R1: hold reset with live inputs; outputs must read zero throughout.
    task automatic do_reset();
        rst_n = 1'b0;
        cmd_i = CW'($urandom); bxid_i = IW'($urandom);
        repeat (3) @(posedge clk);
        @(negedge clk);
        exp_cmd = '0; exp_id = '0;
        compare("R1");
        q_cmd.delete(); q_id.delete();
        rst_n = 1'b1;
    endtask

    function automatic logic [CW*DW-1:0] cfg_all(input int d);
        logic [CW*DW-1:0] r;
        for (int b = 0; b < CW; b++) r[b*DW +: DW] = DW'(d);
        return r;
    endfunction

    // R4/R8: line b takes delay (b + off) mod 32.
    function automatic logic [CW*DW-1:0] cfg_spread(input int off);
        logic [CW*DW-1:0] r;
        for (int b = 0; b < CW; b++) r[b*DW +: DW] = DW'((b + off) % 32);
        return r;
    endfunction

    initial begin
        logic [IW-1:0] bx = '0;
        dly_cfg_i = '0; cmd_i = '0; bxid_i = '0;
        @(negedge clk);
        do_reset();
        // R2: every line set to zero delay.
        for (int i = 0; i < 40; i++) begin
            step(CW'($urandom), bx, cfg_all(0), "R2"); bx++;
        end
        // R3: every line set to delay 1, then a walking pattern at delay 7.
        for (int i = 0; i < 20; i++) begin
            step(CW'($urandom), bx, cfg_all(1), "R3"); bx++;
        end
        for (int i = 0; i < 30; i++) begin
            step(CW'(1) << (i % CW), bx, cfg_all(7), "R3"); bx++;
        end
        // R4/R8: independent per-line delays 0..23.
        for (int i = 0; i < 60; i++) begin
            step(CW'($urandom), bx, cfg_spread(0), "R4"); bx++;
        end
        // R6: settings change each few cycles in the middle of a stream.
        for (int i = 0; i < 80; i++) begin
            step(CW'($urandom), bx, cfg_spread((i / 5) * 3), "R6"); bx++;
        end
        // R7: largest delay on every line, long enough to wrap the history twice.
        for (int i = 0; i < 80; i++) begin
            step(CW'($urandom), bx, cfg_all(31), "R7"); bx++;
        end
        // R1: a reset with data in flight empties the history.
        do_reset();
        for (int i = 0; i < 40; i++) begin
            step(CW'($urandom), bx, cfg_all(31), "R1"); bx++;
        end
        // R4: mixed settings at both ends of the range.
        for (int i = 0; i < 50; i++) begin
            step(CW'($urandom), bx, cfg_spread(20), "R4"); bx++;
        end
        compare("R3");
        summary_and_end();
    end
endmodule